// File: doc/BRIEF.md
# Mode-Selected Clock Ratio Divider

This block sits behind the frequency synthesizer of a system clock generator. It takes one fast source clock and a three-bit select code, and produces the processor clock and the peripheral clock as registered waveforms. It also produces one-cycle rising-edge strobes for the processor, peripheral, 48 MHz-class, reference and interrupt-controller outputs, plus one output enable that governs all of the pads. The source clock runs at twice the processor rate, so the processor clock is always the source divided by two. The peripheral clock is the processor clock divided by two or by three, depending on the frequency bit of the select code. Its rising edge is placed one source cycle after a processor rising edge, so the processor edge always leads.

In the test code, every output is derived from the source clock, which then acts as the test clock, at fixed ratios. The 3-state code and the reserved codes drop the output enable and hold every output low. The reserved codes also raise an error flag. While outputs are running, a new code takes effect only when the current peripheral period ends, so no peripheral period is ever cut short. From the 3-state or reserved codes a new code takes effect at once. In the active codes, the 48 MHz-class and reference strobes are passed through from tick inputs that the other synthesizer branches supply.

Top module: `clock_ratio_divider`

## Requirements
- R1: While reset is asserted, every clock, strobe, the output enable and the error flag are low.
- R2: Select code 3'b000 ({freqSel, s1, s0}) holds the output enable low, every clock and strobe low, and the error flag low.
- R3: Select codes 3'b001, 3'b010, 3'b101 and 3'b110 hold the output enable and every output low and raise the error flag. This also applies when such a code is entered from a running mode.
- R4: Code 3'b011 raises the output enable. The processor clock rises every 2 source cycles and is high for 1 of them. The peripheral clock rises every 4 source cycles and is high for 2 of them.
- R5: Code 3'b111 raises the output enable. The processor clock rises every 2 source cycles. The peripheral clock rises every 6 source cycles and is high for 3 of them.
- R6: Every peripheral rising-edge strobe comes exactly one source cycle after a processor rising-edge strobe.
- R7: Code 3'b100 (test) gives the processor strobe every 2 cycles, the peripheral strobe every 6 cycles, the 48 MHz-class strobe every 2 cycles, and the reference and interrupt-controller strobes every cycle.
- R8: In codes 3'b011 and 3'b111, each cycle with refTick high gives refRise and apicRise high in the following cycle. Each cycle with usbTick high gives usbRise high in the following cycle.
- R9: A code change while outputs run takes effect only at the end of the current peripheral period. The interval between the last old-ratio peripheral edge and the next one equals the old period, and later intervals equal the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (test clock in test code) |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Select code {freqSel, s1, s0} |
| refTick | input | 1 | Reference-rate tick for active codes |
| usbTick | input | 1 | 48 MHz-class tick for active codes |
| cpuClk | output | 1 | Processor clock waveform |
| pciClk | output | 1 | Peripheral clock waveform |
| cpuRise | output | 1 | Processor rising-edge strobe |
| pciRise | output | 1 | Peripheral rising-edge strobe |
| usbRise | output | 1 | 48 MHz-class rising-edge strobe |
| refRise | output | 1 | Reference rising-edge strobe |
| apicRise | output | 1 | Interrupt-controller rising-edge strobe |
| outEn | output | 1 | Output enable for all pads |
| modeErr | output | 1 | Reserved select code in force |

## Verification
The bench goes after the switch from divide-by-two to divide-by-three issued just after a peripheral edge. A divider that reloads at once would give a peripheral interval of three cycles or less there, and the bench measures that interval exactly. Each code is entered through the table and the edge counts are checked over a window of 24 cycles. A wrong ratio, a duty cycle off target, or a reference strobe missing in test mode would all change those counts. Each peripheral edge is also checked to follow a processor edge by one cycle, which catches a peripheral edge placed on the same cycle. Finally, a reserved code is entered from a running mode, where a design that left the enable high or the error flag low is reported.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_RSV,
    MODE_LO,
    MODE_HI,
    MODE_TEST
  } mode_e;

  // strobes from control to datapath, valid for the current source cycle
  typedef struct packed {
    logic run;    // outputs enabled
    logic test;   // test-code ratios in force
    logic cpuHi;  // processor clock level for this cycle
    logic pciHi;  // peripheral clock level for this cycle
    logic err;    // reserved code in force
  } ctl_s;

  function automatic mode_e decodeSel(input logic [2:0] sel);
    mode_e m;
    case (sel)
      3'b000:  m = MODE_OFF;
      3'b011:  m = MODE_LO;
      3'b111:  m = MODE_HI;
      3'b100:  m = MODE_TEST;
      default: m = MODE_RSV;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/crd_ctrl.sv
module crd_ctrl
  import crd_pkg::*;
#(
  parameter int LO_RATIO   = 2,
  parameter int HI_RATIO   = 3,
  parameter int TEST_RATIO = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  output ctl_s       ctl
);

  localparam int MAX_RATIO = (LO_RATIO > HI_RATIO) ?
                             ((LO_RATIO > TEST_RATIO) ? LO_RATIO : TEST_RATIO) :
                             ((HI_RATIO > TEST_RATIO) ? HI_RATIO : TEST_RATIO);
  localparam int CNT_W = $clog2(2 * MAX_RATIO);
  localparam logic [CNT_W-1:0] LAST_LO   = CNT_W'(2 * LO_RATIO - 1);
  localparam logic [CNT_W-1:0] LAST_HI   = CNT_W'(2 * HI_RATIO - 1);
  localparam logic [CNT_W-1:0] LAST_TEST = CNT_W'(2 * TEST_RATIO - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  mode_e            curMode;
  mode_e            reqMode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] ratio;
  logic             running;
  logic             atWrap;

  always_comb begin
    reqMode = decodeSel(modeSel);
    case (curMode)
      MODE_LO:   begin lastCnt = LAST_LO;   ratio = CNT_W'(LO_RATIO);   end
      MODE_HI:   begin lastCnt = LAST_HI;   ratio = CNT_W'(HI_RATIO);   end
      MODE_TEST: begin lastCnt = LAST_TEST; ratio = CNT_W'(TEST_RATIO); end
      default:   begin lastCnt = '0;        ratio = '0;                 end
    endcase
    running = (curMode == MODE_LO) || (curMode == MODE_HI) || (curMode == MODE_TEST);
    atWrap  = (cnt == lastCnt);
  end

  // a pending code is applied only when idle or at the peripheral period end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_OFF;
      cnt     <= '0;
    end else if (!running || atWrap) begin
      curMode <= reqMode;
      cnt     <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  always_comb begin
    ctl.run   = running;
    ctl.test  = (curMode == MODE_TEST);
    ctl.cpuHi = running && !cnt[0];
    ctl.pciHi = running && (cnt >= ONE) && (cnt <= ratio);
    ctl.err   = (curMode == MODE_RSV);
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt); // R4

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (cnt == '0)); // R2

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode != $past(curMode)) && $past(running)) |-> ($past(cnt) == $past(lastCnt))); // R9

endmodule

// File: rtl/crd_datapath.sv
module crd_datapath
  import crd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctl_s ctl,
  input  logic refTick,
  input  logic usbTick,
  output logic cpuClk,
  output logic pciClk,
  output logic cpuRise,
  output logic pciRise,
  output logic usbRise,
  output logic refRise,
  output logic apicRise,
  output logic outEn,
  output logic modeErr
);

  logic cpuEdgeNext;
  logic refNext;

  always_comb begin
    cpuEdgeNext = ctl.cpuHi && !cpuClk;
    refNext     = ctl.test || (ctl.run && refTick);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClk   <= 1'b0;
      pciClk   <= 1'b0;
      cpuRise  <= 1'b0;
      pciRise  <= 1'b0;
      usbRise  <= 1'b0;
      refRise  <= 1'b0;
      apicRise <= 1'b0;
      outEn    <= 1'b0;
      modeErr  <= 1'b0;
    end else begin
      cpuClk   <= ctl.cpuHi;
      pciClk   <= ctl.pciHi;
      cpuRise  <= cpuEdgeNext;
      pciRise  <= ctl.pciHi && !pciClk;
      usbRise  <= ctl.test ? cpuEdgeNext : (ctl.run && usbTick);
      refRise  <= refNext;
      apicRise <= refNext;
      outEn    <= ctl.run;
      modeErr  <= ctl.err;
    end
  end

  AST_PCI_AFTER_CPU: assert property (@(posedge clk) disable iff (!rstN)
    pciRise |-> $past(cpuRise)); // R6

  AST_CPU_HALF: assert property (@(posedge clk) disable iff (!rstN)
    cpuRise |=> !cpuClk); // R4

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !(cpuClk || pciClk || usbRise || refRise || apicRise)); // R2

  AST_ERR_NOT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> !outEn); // R3

endmodule

// File: rtl/clock_ratio_divider.sv
module clock_ratio_divider
  import crd_pkg::*;
#(
  parameter int LO_RATIO   = 2,
  parameter int HI_RATIO   = 3,
  parameter int TEST_RATIO = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       refTick,
  input  logic       usbTick,
  output logic       cpuClk,
  output logic       pciClk,
  output logic       cpuRise,
  output logic       pciRise,
  output logic       usbRise,
  output logic       refRise,
  output logic       apicRise,
  output logic       outEn,
  output logic       modeErr
);

  ctl_s ctl;

  crd_ctrl #(
    .LO_RATIO  (LO_RATIO),
    .HI_RATIO  (HI_RATIO),
    .TEST_RATIO(TEST_RATIO)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .ctl    (ctl)
  );

  crd_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .refTick (refTick),
    .usbTick (usbTick),
    .cpuClk  (cpuClk),
    .pciClk  (pciClk),
    .cpuRise (cpuRise),
    .pciRise (pciRise),
    .usbRise (usbRise),
    .refRise (refRise),
    .apicRise(apicRise),
    .outEn   (outEn),
    .modeErr (modeErr)
  );

endmodule

// File: tb/clock_ratio_divider_test.sv
`timescale 1ns/1ps
module clock_ratio_divider_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic refTick = 1'b0;
  logic usbTick = 1'b0;
  logic cpuClk, pciClk, cpuRise, pciRise, usbRise, refRise, apicRise, outEn, modeErr;

  clock_ratio_divider uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refTick(refTick), .usbTick(usbTick),
    .cpuClk(cpuClk), .pciClk(pciClk), .cpuRise(cpuRise), .pciRise(pciRise),
    .usbRise(usbRise), .refRise(refRise), .apicRise(apicRise),
    .outEn(outEn), .modeErr(modeErr)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;

  // {code[3], oe, err, cpuN[5], pciN[5], pciHiN[5], usbN[5], refN[5]} over 24 cycles
  localparam logic [29:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
    {3'b001, 1'b0, 1'b1, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
    {3'b010, 1'b0, 1'b1, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
    {3'b011, 1'b1, 1'b0, 5'd12, 5'd6, 5'd12, 5'd0,  5'd0},
    {3'b100, 1'b1, 1'b0, 5'd12, 5'd4, 5'd12, 5'd12, 5'd24},
    {3'b101, 1'b0, 1'b1, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
    {3'b110, 1'b0, 1'b1, 5'd0,  5'd0, 5'd0,  5'd0,  5'd0},
    {3'b111, 1'b1, 1'b0, 5'd12, 5'd4, 5'd12, 5'd0,  5'd0}
  };

  int mCpu, mPci, mPciHi, mUsb, mRef, mApic, mOe, mErr, mOrderBad;
  int mMinIvl, mMaxIvl, mFirstIvl, mLastIvl;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // sample n cycles at negedge; startLast >= 0 seeds the last peripheral edge index
  task automatic measure(input int n, input int startLast);
    int lastIdx;
    logic prevCpu;
    mCpu = 0; mPci = 0; mPciHi = 0; mUsb = 0; mRef = 0; mApic = 0;
    mOe = 0; mErr = 0; mOrderBad = 0;
    mMinIvl = 1000; mMaxIvl = 0; mFirstIvl = 0; mLastIvl = 0;
    lastIdx = startLast;
    prevCpu = (startLast >= 0);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      mCpu   += int'(cpuRise);
      mPci   += int'(pciRise);
      mPciHi += int'(pciClk);
      mUsb   += int'(usbRise);
      mRef   += int'(refRise);
      mApic  += int'(apicRise);
      mOe    += int'(outEn);
      mErr   += int'(modeErr);
      if (pciRise && !prevCpu && i > 1) mOrderBad++;
      if (pciRise) begin
        if (lastIdx >= 0) begin
          if (mFirstIvl == 0) mFirstIvl = i - lastIdx;
          mLastIvl = i - lastIdx;
          if (i - lastIdx < mMinIvl) mMinIvl = i - lastIdx;
          if (i - lastIdx > mMaxIvl) mMaxIvl = i - lastIdx;
        end
        lastIdx = i;
      end
      prevCpu = cpuRise;
    end
  endtask

  function automatic string tagFor(input logic [2:0] code);
    case (code)
      3'b000:  return "R2";
      3'b011:  return "R4";
      3'b111:  return "R5";
      3'b100:  return "R7";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outputs in reset",
          int'(cpuClk) + int'(pciClk) + int'(cpuRise) + int'(pciRise) + int'(usbRise) +
          int'(refRise) + int'(apicRise) + int'(outEn) + int'(modeErr), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // table walk over every select code
    for (int k = 0; k < 8; k++) begin
      logic [29:0] v;
      string tag;
      v = VEC[k];
      tag = tagFor(v[29:27]);
      modeSel = 3'b000;
      repeat (10) @(negedge clk);
      modeSel = v[29:27];
      repeat (4) @(negedge clk);
      measure(24, -1);
      check({tag, " outEn"},  mOe,    v[26] ? 24 : 0);
      check({tag, " modeErr"}, mErr,  v[25] ? 24 : 0);
      check({tag, " cpu edges"}, mCpu, int'(v[24:20]));
      check({tag, " pci edges"}, mPci, int'(v[19:15]));
      check({tag, " pci high cycles"}, mPciHi, int'(v[14:10]));
      check({tag, " usb edges"}, mUsb, int'(v[9:5]));
      check({tag, " ref edges"}, mRef, int'(v[4:0]));
      check({tag, " apic edges"}, mApic, int'(v[4:0]));
      check("R6 pci edge follows cpu edge", mOrderBad, 0);
      if (v[19:15] != 0) begin
        check({tag, " pci period max"}, mMaxIvl, 24 / int'(v[19:15]));
        check({tag, " pci period min"}, mMinIvl, 24 / int'(v[19:15]));
      end
    end

    // R8: tick passthrough in the slow active code
    modeSel = 3'b000;
    repeat (10) @(negedge clk);
    modeSel = 3'b011;
    repeat (6) @(negedge clk);
    refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
    usbTick = 1'b1;
    check("R8 refRise after refTick", int'(refRise), 1);
    check("R8 apicRise after refTick", int'(apicRise), 1);
    check("R8 usbRise idle", int'(usbRise), 0);
    @(negedge clk);
    usbTick = 1'b0;
    check("R8 usbRise after usbTick", int'(usbRise), 1);
    check("R8 refRise idle", int'(refRise), 0);
    @(negedge clk);
    check("R8 usbRise cleared", int'(usbRise), 0);

    // R9: switch ratio right after a peripheral edge
    while (!pciRise) @(negedge clk);
    modeSel = 3'b111;
    measure(40, 0);
    check("R9 first interval keeps old period", mFirstIvl, 4);
    check("R9 no shortened period", int'(mMinIvl >= 4), 1);
    check("R9 new period after switch", mLastIvl, 6);
    check("R9 enable held through switch", mOe, 40);
    check("R6 order across switch", mOrderBad, 0);

    // R3: reserved code entered from a running code
    modeSel = 3'b001;
    repeat (10) @(negedge clk);
    check("R3 error after running", int'(modeErr), 1);
    check("R3 enable dropped after running", int'(outEn), 0);
    check("R3 clocks low after running", int'(cpuClk) + int'(pciClk), 0);

    finishRun();
  end

endmodule